// File: doc/BRIEF.md
# Fixed-Priority Banked Memory Controller

This block lets three independent requesters share one on-chip RAM: a host loader port, the processor's data port and the processor's instruction fetch port. In every cycle at most one of them is granted. The winner is picked by a fixed priority order. The granted request is steered through a write crossbar to one of four subbanks. For a read, the data comes back through a read crossbar one cycle later and is routed only to the requester that won.

Each port is decoupled. A requester holds its request and watches its grant. A denied requester just tries again later, and the other ports keep running. A hold input stops all grants to the two processor ports while the host still gets through. The hold is expected to be high out of reset, so the host can fill memory before the processor starts.

Top module: `mem_ctrl`

## Requirements
- R1: While and right after a synchronous active-low reset, no response-valid output is high.
- R2: A host request is always granted in the cycle it is presented, whatever the other ports do.
- R3: When the host is idle and the hold is low, a data request wins over a fetch request. A fetch request is granted only when neither of the others is requesting.
- R4: At most one grant is high in any cycle, and at most one response-valid is high. A grant is given only to a port that is requesting.
- R5: While `cpu_hold` is high, neither `dmem_gnt` nor `fetch_gnt` is ever given. The host is still served.
- R6: A granted read returns its word one cycle after the grant edge. It is marked by a one-cycle valid on the port that won and on no other port.
- R7: A granted write updates only the byte lanes whose enable bit is set (bit i covers data bits 8i+7..8i). The other bytes of the word keep their old value.
- R8: Addresses are byte addresses and must be word-aligned (bits [1:0] zero). Bits [12:11] select the subbank and bits [10:2] select the word within it. Equal word offsets in different subbanks are separate storage.
- R9: A denied request has no effect. A denied write leaves memory unchanged, and a denied read produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_hold | input | 1 | When high, refuses both processor ports |
| host_req | input | 1 | Host request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 13 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_be | input | 4 | Host byte enables |
| host_gnt | output | 1 | Host granted this cycle |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | 32 | Host read data |
| dmem_req | input | 1 | Data port request |
| dmem_we | input | 1 | Data port write (1) or read (0) |
| dmem_addr | input | 13 | Data port byte address |
| dmem_wdata | input | 32 | Data port write data |
| dmem_be | input | 4 | Data port byte enables |
| dmem_gnt | output | 1 | Data port granted this cycle |
| dmem_rvalid | output | 1 | Data port read data valid |
| dmem_rdata | output | 32 | Data port read data |
| fetch_req | input | 1 | Fetch read request |
| fetch_addr | input | 13 | Fetch byte address |
| fetch_gnt | output | 1 | Fetch granted this cycle |
| fetch_rvalid | output | 1 | Fetch read data valid |
| fetch_rdata | output | 32 | Fetch read data |

## Verification
The bench builds the block with its defaults: 32-bit words, four subbanks of 2048 bytes each, and therefore a 13-bit address. With the hold high, the host first writes a distinct value to every one of the 2048 words while both processor ports request at random. This places every subbank and every word offset within reach of later reads and exposes any aliasing between subbanks. A random phase follows with the hold mostly low. It mixes reads and partial-byte writes from all three ports, and a bench scoreboard predicts each grant and each returned word.

// File: rtl/mc_pkg.sv
// Shared definitions for the banked memory controller.
// Assumes three requesters; index order is also priority order.
package mc_pkg;
    localparam int NUM_REQ = 3;

    typedef enum logic [1:0] {
        REQ_HOST  = 2'd0,
        REQ_DATA  = 2'd1,
        REQ_FETCH = 2'd2
    } req_id_e;
endpackage

// File: rtl/mc_arbiter.sv
// Fixed-priority arbiter: lowest index wins. Index 0 (host) ignores the hold;
// all higher indices are refused while cpu_hold is high.
// Assumes requests are stable for the whole cycle; grants are combinational.
module mc_arbiter
    import mc_pkg::*;
#(
    parameter int N = NUM_REQ
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cpu_hold,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic [N-1:0] eligible;

    // Mask processor requesters while held.
    always_comb begin
        eligible = req;
        for (int i = 1; i < N; i++) begin
            if (cpu_hold) eligible[i] = 1'b0;
        end
    end

    // Pick the lowest eligible index.
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (eligible[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((gnt & ~req) == '0));
    assert_host_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req[REQ_HOST] |-> gnt[REQ_HOST]);
    assert_data_over_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req[REQ_DATA] && !req[REQ_HOST] && !cpu_hold) |-> (gnt[REQ_DATA] && !gnt[REQ_FETCH]));
    assert_hold_blocks_cpu_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hold |-> (!gnt[REQ_DATA] && !gnt[REQ_FETCH]));
endmodule

// File: rtl/mc_subbank.sv
// Behavioural single-port subbank with byte write enables.
// Assumes one access per cycle; read data is registered and held until the next read.
module mc_subbank #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 512,
    localparam int BE_W  = DATA_W / 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [BE_W-1:0]   be,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Byte-lane writes.
    always_ff @(posedge clk) begin
        if (en && we) begin
            for (int b = 0; b < BE_W; b++) begin
                if (be[b]) mem[idx][b*8 +: 8] <= wdata[b*8 +: 8];
            end
        end
    end

    // Registered read.
    always_ff @(posedge clk) begin
        if (en && !we) rdata <= mem[idx];
    end
endmodule

// File: rtl/mc_rdxbar.sv
// Read crossbar: picks one subbank's read data by a registered bank index.
// Assumes the index was captured on the same edge the subbank registered its data.
module mc_rdxbar #(
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic [DATA_W-1:0] bank_rdata [NUM_BANKS],
    input  logic [BANK_W-1:0] sel,
    output logic [DATA_W-1:0] rdata
);
    // Plain index mux.
    always_comb rdata = bank_rdata[sel];
endmodule

// File: rtl/mem_ctrl.sv
// Top: three-port fixed-priority controller over NUM_BANKS subbanks.
// The winner's request goes to the subbank named by the top address bits.
// Read data returns one cycle later, only on the winner's port.
// Assumes word-aligned byte addresses and requesters that hold requests until granted.
module mem_ctrl
    import mc_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int BANK_BYTES = 2048,
    parameter int NUM_BANKS  = 4,
    localparam int BE_W      = DATA_W / 8,
    localparam int OFF_W     = $clog2(BE_W),
    localparam int DEPTH     = BANK_BYTES / BE_W,
    localparam int WORD_W    = $clog2(DEPTH),
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int ADDR_W    = OFF_W + WORD_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_hold,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [BE_W-1:0]   host_be,
    output logic              host_gnt,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              dmem_req,
    input  logic              dmem_we,
    input  logic [ADDR_W-1:0] dmem_addr,
    input  logic [DATA_W-1:0] dmem_wdata,
    input  logic [BE_W-1:0]   dmem_be,
    output logic              dmem_gnt,
    output logic              dmem_rvalid,
    output logic [DATA_W-1:0] dmem_rdata,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_gnt,
    output logic              fetch_rvalid,
    output logic [DATA_W-1:0] fetch_rdata
);
    logic [NUM_REQ-1:0] req_vec, gnt_vec;
    logic               sel_valid, sel_we;
    logic [ADDR_W-1:0]  sel_addr;
    logic [DATA_W-1:0]  sel_wdata;
    logic [BE_W-1:0]    sel_be;
    logic [BANK_W-1:0]  sel_bank;
    logic [WORD_W-1:0]  sel_word;
    logic [NUM_REQ-1:0] rsp_owner;
    logic [BANK_W-1:0]  rsp_bank;
    logic [DATA_W-1:0]  bank_rdata [NUM_BANKS];
    logic [DATA_W-1:0]  rsp_data;

    assign req_vec = {fetch_req, dmem_req, host_req};

    mc_arbiter #(.N(NUM_REQ)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_hold (cpu_hold),
        .req      (req_vec),
        .gnt      (gnt_vec)
    );

    assign host_gnt  = gnt_vec[REQ_HOST];
    assign dmem_gnt  = gnt_vec[REQ_DATA];
    assign fetch_gnt = gnt_vec[REQ_FETCH];

    // Write crossbar: forward the granted requester's fields.
    always_comb begin
        sel_valid = |gnt_vec;
        sel_we    = host_we;
        sel_addr  = host_addr;
        sel_wdata = host_wdata;
        sel_be    = host_be;
        if (gnt_vec[REQ_DATA]) begin
            sel_we    = dmem_we;
            sel_addr  = dmem_addr;
            sel_wdata = dmem_wdata;
            sel_be    = dmem_be;
        end else if (gnt_vec[REQ_FETCH]) begin
            sel_we    = 1'b0;
            sel_addr  = fetch_addr;
            sel_wdata = '0;
            sel_be    = '0;
        end
    end

    assign sel_bank = sel_addr[ADDR_W-1 -: BANK_W];
    assign sel_word = sel_addr[OFF_W +: WORD_W];

    // One subbank per bank index; enabled only when addressed.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        mc_subbank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_sb (
            .clk   (clk),
            .en    (sel_valid && (sel_bank == BANK_W'(b))),
            .we    (sel_we),
            .be    (sel_be),
            .idx   (sel_word),
            .wdata (sel_wdata),
            .rdata (bank_rdata[b])
        );
    end

    // Response routing: remember who read and from which bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_owner <= '0;
            rsp_bank  <= '0;
        end else begin
            rsp_owner <= sel_we ? '0 : gnt_vec;
            rsp_bank  <= sel_bank;
        end
    end

    mc_rdxbar #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) u_rdx (
        .bank_rdata (bank_rdata),
        .sel        (rsp_bank),
        .rdata      (rsp_data)
    );

    assign host_rvalid  = rsp_owner[REQ_HOST];
    assign dmem_rvalid  = rsp_owner[REQ_DATA];
    assign fetch_rvalid = rsp_owner[REQ_FETCH];
    assign host_rdata   = rsp_data;
    assign dmem_rdata   = rsp_data;
    assign fetch_rdata  = rsp_data;

    assert_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (sel_addr[OFF_W-1:0] == '0));
    assert_one_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_rvalid, dmem_rvalid, host_rvalid}));
    assert_host_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(host_gnt && !host_we));
    assert_dmem_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rvalid |-> $past(dmem_gnt && !dmem_we));
    assert_fetch_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rvalid |-> $past(fetch_gnt));
endmodule

// File: tb/tb_mem_ctrl.sv
// Bench: host preload under hold, then a random mix, against a scoreboard.
module tb_mem_ctrl;
    localparam int WORDS = 2048;

    logic        clk = 1'b0, rst_n = 1'b0, cpu_hold = 1'b1;
    logic        host_req = 0, host_we = 0, dmem_req = 0, dmem_we = 0, fetch_req = 0;
    logic [12:0] host_addr = 0, dmem_addr = 0, fetch_addr = 0;
    logic [31:0] host_wdata = 0, dmem_wdata = 0;
    logic [3:0]  host_be = 0, dmem_be = 0;
    logic        host_gnt, dmem_gnt, fetch_gnt;
    logic        host_rvalid, dmem_rvalid, fetch_rvalid;
    logic [31:0] host_rdata, dmem_rdata, fetch_rdata;

    int tests = 0, fails = 0;
    logic done = 1'b0;
    logic [31:0] sb [WORDS];
    logic [2:0]  pend_own = 3'b000;
    logic [31:0] pend_data = '0;

    mem_ctrl dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_gnt(input logic h, input logic d, input logic f, input logic hold);
        if (h) return 3'b001;
        if (hold) return 3'b000;
        if (d) return 3'b010;
        if (f) return 3'b100;
        return 3'b000;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

    // One cycle: check the previous response, drive new inputs, check grants, update the scoreboard.
    task automatic step(input logic h, input logic hw, input logic [10:0] hword, input logic [31:0] hd, input logic [3:0] hb,
                        input logic d, input logic dw, input logic [10:0] dword, input logic [31:0] dd, input logic [3:0] db,
                        input logic f, input logic [10:0] fword, input logic hold);
        logic [2:0] g, eg;
        @(negedge clk);
        chk({fetch_rvalid, dmem_rvalid, host_rvalid} == pend_own, "R6 R9 rvalid routing",
            {29'd0, fetch_rvalid, dmem_rvalid, host_rvalid}, {29'd0, pend_own});
        if (host_rvalid)  chk(host_rdata  == pend_data, "R6 R7 R8 host rdata",  host_rdata,  pend_data);
        if (dmem_rvalid)  chk(dmem_rdata  == pend_data, "R6 R7 R8 dmem rdata",  dmem_rdata,  pend_data);
        if (fetch_rvalid) chk(fetch_rdata == pend_data, "R6 R7 R8 fetch rdata", fetch_rdata, pend_data);
        host_req = h; host_we = hw; host_addr = {hword, 2'b00}; host_wdata = hd; host_be = hb;
        dmem_req = d; dmem_we = dw; dmem_addr = {dword, 2'b00}; dmem_wdata = dd; dmem_be = db;
        fetch_req = f; fetch_addr = {fword, 2'b00}; cpu_hold = hold;
        #1;
        g  = {fetch_gnt, dmem_gnt, host_gnt};
        eg = exp_gnt(h, d, f, hold);
        chk(g == eg, hold ? "R2 R4 R5 grant" : "R2 R3 R4 grant", {29'd0, g}, {29'd0, eg});
        pend_own = 3'b000;
        if (eg[0]) begin
            if (hw) sb[hword] = merge(sb[hword], hd, hb);
            else begin pend_own = 3'b001; pend_data = sb[hword]; end
        end else if (eg[1]) begin
            if (dw) sb[dword] = merge(sb[dword], dd, db);
            else begin pend_own = 3'b010; pend_data = sb[dword]; end
        end else if (eg[2]) begin
            pend_own = 3'b100; pend_data = sb[fword];
        end
    endtask

    initial begin
        void'($urandom(32'h1234_5a5a));
        repeat (3) @(negedge clk);
        chk({fetch_rvalid, dmem_rvalid, host_rvalid} == 3'b000, "R1 reset rvalid",
            {29'd0, fetch_rvalid, dmem_rvalid, host_rvalid}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // Preload every word through the host while held; CPU ports hammer at random (R5).
        for (int w = 0; w < WORDS; w++)
            step(1'b1, 1'b1, 11'(w), {5'h15, 11'(w), 16'(w * 7 + 3)}, 4'hF,
                 1'($urandom), 1'($urandom), 11'($urandom), $urandom, 4'($urandom),
                 1'($urandom), 11'($urandom), 1'b1);
        // Directed: hold with only CPU requests -> nothing granted (R5).
        step(0, 0, 0, 0, 0, 1, 1, 11'd5, 32'hDEAD_BEEF, 4'hF, 1, 11'd5, 1'b1);
        // Directed: same offset in bank 0 and bank 3 read back distinctly (R8).
        step(1, 0, 11'd5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
        step(1, 0, 11'd1541, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
        // Directed: partial write then data-over-fetch read (R3, R7).
        step(1, 1, 11'd9, 32'hA1B2_C3D4, 4'b0101, 0, 0, 0, 0, 0, 0, 0, 1'b0);
        step(0, 0, 0, 0, 0, 1, 0, 11'd9, 0, 0, 1, 11'd10, 1'b0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 11'd10, 1'b0);
        // Random mix.
        for (int i = 0; i < 6000; i++)
            step(($urandom % 3) == 0, 1'($urandom), 11'($urandom), $urandom, 4'($urandom),
                 1'($urandom), 1'($urandom), 11'($urandom), $urandom, 4'($urandom),
                 1'($urandom), 11'($urandom), ($urandom % 8) == 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule